// File: doc/BRIEF.md
# Condition-Driven Serial Timer Channel

One timer channel for a programmable serial I/O engine. A 16-bit compare value and a small set of configuration fields turn the same down-counter into a bit-rate generator with bit counting, a PWM source or a plain 16-bit interval counter. The fields also choose when the channel starts, stops and reloads. These conditions are taken from a trigger input, a pin input and the start and stop pulses of the neighbouring lower-numbered channel.

The channel drives a timer output, a shift clock for an attached shifter, a one-cycle load strobe for that shifter, a pin output enable that is high while the channel runs, and a sticky status flag that marks every compare event. The trigger and pin inputs pass through a polarity inversion and one register stage before any condition looks at them. Shifters, pin routing and the register bus sit outside this block.

Top module: `ser_timer`

## Requirements
- R1: After reset, and whenever `cfg_mode` is 0, `pin_oe`, `tmr_out`, `shift_load` and `flag` are low and the channel stays idle.
- R2: `cfg_trg_inv`/`cfg_pin_inv` invert trigger and pin before every condition: with inversion on, a low `trg_in` counts as trigger high.
- R3: `cfg_ena_sel` starts an idle channel: 0 always, 1 on a `prev_en` pulse (seen on the next edge), 2 trigger high, 3 trigger and pin high, 4 pin rise, 5 pin rise with trigger high, 6 trigger rise, 7 either trigger edge.
- R4: `cfg_dis_sel` stops a running channel: 0 never, 1 on a `prev_dis` pulse, 2 on compare, 3 on compare with trigger low, 4 either pin edge, 5 either pin edge with trigger high, 6 trigger fall, 7 never.
- R5: `cfg_rld_sel` reloads the counter from `cmp_val`: 2 pin equals timer output, 3 trigger equals timer output, 4 pin rise, 6 trigger rise, 7 either trigger edge, other codes never. With `cfg_out_sel[1]`=1 a reload also forces the start level.
- R6: Mode 1 (bit-rate): with `cmp_val` = {H,L} and a tick every cycle, the low byte toggles `tmr_out` every L+1 ticks and the compare event falls after (H+1)(L+1) ticks, so a run that stops on compare keeps `pin_oe` high for (H+1)(L+1) cycles.
- R7: Mode 2 (PWM): `tmr_out` is high for L+1 ticks, then low for H+1 ticks, repeating. The compare event marks the end of the low time.
- R8: Mode 3 (16-bit): the compare event and an output toggle occur every N+1 ticks for `cmp_val` = N.
- R9: On start, `tmr_out` takes the level 1 when `cfg_out_sel[0]`=0 and 0 when it is 1.
- R10: `cfg_dec_sel`: 0 ticks every cycle, 1 and 3 tick on either trigger edge, 2 on either pin edge. `shift_clk` is `tmr_out` for codes 0 and 1, the conditioned pin for 2 and the conditioned trigger for 3.
- R11: With `cfg_start_en`=1 in mode 1, the first low-byte expiry does not count a bit, which adds L+1 ticks to a run.
- R12: `cfg_stop_sel[1]` inserts a stop period of L+1 ticks at the start level before a stop takes effect. `cfg_stop_sel[0]` inserts the same period after each compare and then resumes.
- R13: `flag` rises on the cycle after a compare event. It stays high until a `flag_clr` pulse with no new compare on that edge.
- R14: `shift_load` pulses for one cycle when the channel starts, on the first cycle `pin_oe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | 0 off, 1 bit-rate, 2 PWM, 3 16-bit |
| cfg_out_sel | input | 2 | bit0 start level (0 gives 1), bit1 reload forces level |
| cfg_dec_sel | input | 2 | Tick source and shift clock source |
| cfg_rld_sel | input | 3 | Reload condition |
| cfg_dis_sel | input | 3 | Stop condition |
| cfg_ena_sel | input | 3 | Start condition |
| cfg_stop_sel | input | 2 | bit0 stop period after compare, bit1 before stopping |
| cfg_start_en | input | 1 | Start bit period in mode 1 |
| cfg_trg_inv | input | 1 | Invert trigger |
| cfg_pin_inv | input | 1 | Invert pin |
| cmp_val | input | CW | Compare value {high byte, low byte} |
| trg_in | input | 1 | Trigger input |
| pin_in | input | 1 | Pin input |
| prev_en | input | 1 | Start pulse of the neighbouring channel |
| prev_dis | input | 1 | Stop pulse of the neighbouring channel |
| flag_clr | input | 1 | Write-one clear of the status flag |
| tmr_out | output | 1 | Timer output |
| shift_clk | output | 1 | Shift clock |
| shift_load | output | 1 | Shifter load strobe |
| flag | output | 1 | Sticky compare flag |
| pin_oe | output | 1 | High while the channel runs |

## Verification
The bench sweeps mode 1 over several low and high byte values, each with no extra bit, with a start bit and with a stop period. It checks the run length against (H+1+extra)(L+1). A counter that reloads one tick late, or that treats a zero byte as expired one tick early, moves every such count by a whole bit period. PWM high and low times are measured separately, so swapped byte roles show up as exchanged durations. A reload pulse partway through a 16-bit run must lengthen it by a predictable amount, and a design that missed the reload would stop early. Inverted trigger polarity, neighbour start and stop pulses, trigger-edge ticking and the clear-versus-hold behaviour of the flag are each driven on their own, so a condition applied before inversion or a flag that self-clears fails a named check.

// File: rtl/ser_timer_pkg.sv
package ser_timer_pkg;
  typedef enum logic [1:0] {
    MD_OFF  = 2'd0,
    MD_BAUD = 2'd1,
    MD_PWM  = 2'd2,
    MD_WIDE = 2'd3
  } tmr_mode_e;

  typedef enum logic [1:0] {
    TK_CLK   = 2'd0,
    TK_TRG   = 2'd1,
    TK_PIN   = 2'd2,
    TK_TRGSH = 2'd3
  } tick_src_e;

  // level the output takes when the channel starts
  function automatic logic start_level(input logic [1:0] out_sel);
    return ~out_sel[0];
  endfunction
endpackage

// File: rtl/ser_timer_cond.sv
module ser_timer_cond
  import ser_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       trg_in,
  input  logic       pin_in,
  input  logic       trg_inv,
  input  logic       pin_inv,
  input  logic [2:0] ena_sel,
  input  logic [2:0] dis_sel,
  input  logic [2:0] rld_sel,
  input  logic [1:0] dec_sel,
  input  logic       prev_en,
  input  logic       prev_dis,
  input  logic       tmr_out,
  input  logic       cmp_ev,
  output logic       en_hit,
  output logic       dis_hit,
  output logic       rld_hit,
  output logic       tick,
  output logic       shift_clk
);
  logic trg_q, trg_d, pin_q, pin_d;
  logic trg_rise, trg_fall, pin_rise, pin_fall;

  // polarity applied ahead of the capture register; reset samples the
  // live level so that leaving reset never looks like an edge
  always_ff @(posedge clk) begin
    trg_q <= trg_in ^ trg_inv;
    pin_q <= pin_in ^ pin_inv;
    if (rst) begin
      trg_d <= trg_in ^ trg_inv;
      pin_d <= pin_in ^ pin_inv;
    end else begin
      trg_d <= trg_q;
      pin_d <= pin_q;
    end
  end

  assign trg_rise = trg_q & ~trg_d;
  assign trg_fall = ~trg_q & trg_d;
  assign pin_rise = pin_q & ~pin_d;
  assign pin_fall = ~pin_q & pin_d;

  always_comb begin
    unique case (ena_sel)
      3'd0: en_hit = 1'b1;
      3'd1: en_hit = prev_en;
      3'd2: en_hit = trg_q;
      3'd3: en_hit = trg_q & pin_q;
      3'd4: en_hit = pin_rise;
      3'd5: en_hit = pin_rise & trg_q;
      3'd6: en_hit = trg_rise;
      default: en_hit = trg_rise | trg_fall;
    endcase
  end

  always_comb begin
    unique case (dis_sel)
      3'd1: dis_hit = prev_dis;
      3'd2: dis_hit = cmp_ev;
      3'd3: dis_hit = cmp_ev & ~trg_q;
      3'd4: dis_hit = pin_rise | pin_fall;
      3'd5: dis_hit = (pin_rise | pin_fall) & trg_q;
      3'd6: dis_hit = trg_fall;
      default: dis_hit = 1'b0;
    endcase
  end

  always_comb begin
    unique case (rld_sel)
      3'd2: rld_hit = (pin_q == tmr_out);
      3'd3: rld_hit = (trg_q == tmr_out);
      3'd4: rld_hit = pin_rise;
      3'd6: rld_hit = trg_rise;
      3'd7: rld_hit = trg_rise | trg_fall;
      default: rld_hit = 1'b0;
    endcase
  end

  always_comb begin
    unique case (tick_src_e'(dec_sel))
      TK_CLK:   begin tick = 1'b1;                  shift_clk = tmr_out; end
      TK_TRG:   begin tick = trg_rise | trg_fall;   shift_clk = tmr_out; end
      TK_PIN:   begin tick = pin_rise | pin_fall;   shift_clk = pin_q;   end
      default:  begin tick = trg_rise | trg_fall;   shift_clk = trg_q;   end
    endcase
  end

  // R10: a clock-sourced channel ticks on every cycle
  a_r10_clk_tick: assert property (@(posedge clk) disable iff (rst)
    (dec_sel == 2'd0) |-> tick);
  // R2: the captured trigger follows the inverted input one edge later
  a_r2_trg_polarity: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (trg_q == ($past(trg_in) ^ $past(trg_inv))));
endmodule

// File: rtl/ser_timer_core.sv
module ser_timer_core
  import ser_timer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode,
  input  logic [1:0]    out_sel,
  input  logic          start_en,
  input  logic [1:0]    stop_sel,
  input  logic [CW-1:0] cmp_val,
  input  logic          en_hit,
  input  logic          dis_hit,
  input  logic          rld_hit,
  input  logic          tick,
  output logic          active,
  output logic          out_q,
  output logic          load_q,
  output logic          cmp_ev
);
  localparam int HW = CW / 2;

  logic [CW-1:0] cnt;
  logic [HW-1:0] lo, hi, cmp_lo, cmp_hi;
  logic          lo_zero, hi_zero, start_pend, stop_ph, stop_off, run, lvl;
  tmr_mode_e     md;

  assign md      = tmr_mode_e'(mode);
  assign lo      = cnt[HW-1:0];
  assign hi      = cnt[CW-1:HW];
  assign cmp_lo  = cmp_val[HW-1:0];
  assign cmp_hi  = cmp_val[CW-1:HW];
  assign lo_zero = (lo == '0);
  assign hi_zero = (hi == '0);
  assign lvl     = start_level(out_sel);
  assign run     = active & ~stop_ph & tick;

  always_comb begin
    unique case (md)
      MD_BAUD: cmp_ev = run & lo_zero & hi_zero & ~start_pend;
      MD_PWM:  cmp_ev = run & ~out_q & hi_zero;
      MD_WIDE: cmp_ev = run & lo_zero & hi_zero;
      default: cmp_ev = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      out_q      <= 1'b0;
      load_q     <= 1'b0;
      cnt        <= '0;
      start_pend <= 1'b0;
      stop_ph    <= 1'b0;
      stop_off   <= 1'b0;
    end else begin
      load_q <= 1'b0;
      if (md == MD_OFF) begin
        active  <= 1'b0;
        out_q   <= 1'b0;
        stop_ph <= 1'b0;
      end else if (!active) begin
        if (en_hit) begin
          active     <= 1'b1;
          cnt        <= cmp_val;
          out_q      <= lvl;
          start_pend <= start_en & (md == MD_BAUD);
          stop_ph    <= 1'b0;
          load_q     <= 1'b1;
        end
      end else if (stop_ph) begin
        if (tick) begin
          if (lo_zero) begin
            stop_ph <= 1'b0;
            if (stop_off) begin
              active <= 1'b0;
              out_q  <= 1'b0;
            end else begin
              cnt    <= cmp_val;
              out_q  <= lvl;
              load_q <= 1'b1;
            end
          end else begin
            cnt[HW-1:0] <= lo - 1'b1;
          end
        end
      end else if (dis_hit) begin
        if (stop_sel[1]) begin
          stop_ph     <= 1'b1;
          stop_off    <= 1'b1;
          cnt[HW-1:0] <= cmp_lo;
          out_q       <= lvl;
        end else begin
          active <= 1'b0;
          out_q  <= 1'b0;
        end
      end else if (cmp_ev && stop_sel[0]) begin
        stop_ph     <= 1'b1;
        stop_off    <= 1'b0;
        cnt[HW-1:0] <= cmp_lo;
        out_q       <= lvl;
      end else if (rld_hit) begin
        cnt <= cmp_val;
        if (out_sel[1]) out_q <= lvl;
      end else if (tick) begin
        load_q <= cmp_ev;
        unique case (md)
          MD_BAUD: begin
            if (lo_zero) begin
              cnt[HW-1:0] <= cmp_lo;
              out_q       <= ~out_q;
              if (start_pend)   start_pend   <= 1'b0;
              else if (hi_zero) cnt[CW-1:HW] <= cmp_hi;
              else              cnt[CW-1:HW] <= hi - 1'b1;
            end else begin
              cnt[HW-1:0] <= lo - 1'b1;
            end
          end
          MD_PWM: begin
            if (out_q) begin
              if (lo_zero) begin
                out_q       <= 1'b0;
                cnt[HW-1:0] <= cmp_lo;
              end else cnt[HW-1:0] <= lo - 1'b1;
            end else begin
              if (hi_zero) begin
                out_q        <= 1'b1;
                cnt[CW-1:HW] <= cmp_hi;
              end else cnt[CW-1:HW] <= hi - 1'b1;
            end
          end
          default: begin
            if (lo_zero && hi_zero) begin
              cnt   <= cmp_val;
              out_q <= ~out_q;
            end else cnt <= cnt - 1'b1;
          end
        endcase
      end
    end
  end

  // R1: an off channel is idle and quiet one edge later
  a_r1_off_idle: assert property (@(posedge clk) disable iff (rst)
    (md == MD_OFF) |=> (!active && !out_q));
  // R14: the load strobe only appears while the channel runs
  a_r14_load_active: assert property (@(posedge clk) disable iff (rst)
    load_q |-> active);
  // R6: without a tick, reload or stop the count does not move
  a_r6_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
    (active && !stop_ph && !tick && !dis_hit && !rld_hit && md != MD_OFF) |=> $stable(cnt));
  // R1: output is low whenever the channel is idle
  a_r1_idle_low: assert property (@(posedge clk) disable iff (rst)
    !active |-> !out_q);
endmodule

// File: rtl/ser_timer.sv
module ser_timer
  import ser_timer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    cfg_mode,
  input  logic [1:0]    cfg_out_sel,
  input  logic [1:0]    cfg_dec_sel,
  input  logic [2:0]    cfg_rld_sel,
  input  logic [2:0]    cfg_dis_sel,
  input  logic [2:0]    cfg_ena_sel,
  input  logic [1:0]    cfg_stop_sel,
  input  logic          cfg_start_en,
  input  logic          cfg_trg_inv,
  input  logic          cfg_pin_inv,
  input  logic [CW-1:0] cmp_val,
  input  logic          trg_in,
  input  logic          pin_in,
  input  logic          prev_en,
  input  logic          prev_dis,
  input  logic          flag_clr,
  output logic          tmr_out,
  output logic          shift_clk,
  output logic          shift_load,
  output logic          flag,
  output logic          pin_oe
);
  logic en_hit, dis_hit, rld_hit, tick, cmp_ev, active, out_q, load_q, flag_q;

  ser_timer_cond u_cond (
    .clk       (clk),
    .rst       (rst),
    .trg_in    (trg_in),
    .pin_in    (pin_in),
    .trg_inv   (cfg_trg_inv),
    .pin_inv   (cfg_pin_inv),
    .ena_sel   (cfg_ena_sel),
    .dis_sel   (cfg_dis_sel),
    .rld_sel   (cfg_rld_sel),
    .dec_sel   (cfg_dec_sel),
    .prev_en   (prev_en),
    .prev_dis  (prev_dis),
    .tmr_out   (out_q),
    .cmp_ev    (cmp_ev),
    .en_hit    (en_hit),
    .dis_hit   (dis_hit),
    .rld_hit   (rld_hit),
    .tick      (tick),
    .shift_clk (shift_clk)
  );

  ser_timer_core #(.CW(CW)) u_core (
    .clk      (clk),
    .rst      (rst),
    .mode     (cfg_mode),
    .out_sel  (cfg_out_sel),
    .start_en (cfg_start_en),
    .stop_sel (cfg_stop_sel),
    .cmp_val  (cmp_val),
    .en_hit   (en_hit),
    .dis_hit  (dis_hit),
    .rld_hit  (rld_hit),
    .tick     (tick),
    .active   (active),
    .out_q    (out_q),
    .load_q   (load_q),
    .cmp_ev   (cmp_ev)
  );

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= cmp_ev | (flag_q & ~flag_clr);
  end

  assign tmr_out    = out_q;
  assign pin_oe     = active;
  assign shift_load = load_q;
  assign flag       = flag_q;

  // R13: a compare event always leaves the flag set
  a_r13_cmp_sets: assert property (@(posedge clk) disable iff (rst)
    cmp_ev |=> flag_q);
  // R13: without a clear the flag never drops
  a_r13_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !flag_clr) |=> flag_q);
endmodule

// File: tb/ser_timer_tb.sv
module ser_timer_tb;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cfg_mode = 2'd0, cfg_out_sel = 2'd0, cfg_dec_sel = 2'd0, cfg_stop_sel = 2'd0;
  logic [2:0] cfg_rld_sel = 3'd0, cfg_dis_sel = 3'd0, cfg_ena_sel = 3'd0;
  logic cfg_start_en = 1'b0, cfg_trg_inv = 1'b0, cfg_pin_inv = 1'b0;
  logic [CW-1:0] cmp_val = '0;
  logic trg_in = 1'b0, pin_in = 1'b0, prev_en = 1'b0, prev_dis = 1'b0, flag_clr = 1'b0;
  logic tmr_out, shift_clk, shift_load, flag, pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ser_timer #(.CW(CW)) u_dut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_out_sel(cfg_out_sel),
    .cfg_dec_sel(cfg_dec_sel), .cfg_rld_sel(cfg_rld_sel), .cfg_dis_sel(cfg_dis_sel),
    .cfg_ena_sel(cfg_ena_sel), .cfg_stop_sel(cfg_stop_sel), .cfg_start_en(cfg_start_en),
    .cfg_trg_inv(cfg_trg_inv), .cfg_pin_inv(cfg_pin_inv), .cmp_val(cmp_val),
    .trg_in(trg_in), .pin_in(pin_in), .prev_en(prev_en), .prev_dis(prev_dis),
    .flag_clr(flag_clr), .tmr_out(tmr_out), .shift_clk(shift_clk),
    .shift_load(shift_load), .flag(flag), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic defaults();
    cfg_mode = 2'd0; cfg_out_sel = 2'd0; cfg_dec_sel = 2'd0; cfg_stop_sel = 2'd0;
    cfg_rld_sel = 3'd0; cfg_dis_sel = 3'd0; cfg_ena_sel = 3'd0;
    cfg_start_en = 1'b0; cfg_trg_inv = 1'b0; cfg_pin_inv = 1'b0; cmp_val = '0;
    trg_in = 1'b0; pin_in = 1'b0; prev_en = 1'b0; prev_dis = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(3);
    rst = 1'b0;
  endtask

  // waits for the run to start, counts the samples with pin_oe high;
  // optionally raises trg_in after poke_at samples
  task automatic run_len(input int poke_at, output int len, output int first_out,
                         output int first_load, output int end_flag);
    int guard = 0;
    len = -1; first_out = -1; first_load = -1; end_flag = -1;
    while (!pin_oe && guard < 5000) begin step(1); guard++; end
    if (pin_oe) begin
      len = 0;
      first_out = int'(tmr_out);
      first_load = int'(shift_load);
      while (pin_oe && len < 5000) begin
        len++;
        if (len == poke_at) trg_in = 1'b1;
        step(1);
      end
      end_flag = int'(flag);
    end
  endtask

  initial begin
    int len, fo, fl, ef;
    int los[3] = '{0, 1, 3};
    int his[3] = '{0, 1, 5};
    defaults();
    do_reset();
    step(2);
    // R1: reset and mode 0 leave everything low
    check("R1 pin_oe idle", int'(pin_oe), 0);
    check("R1 tmr_out idle", int'(tmr_out), 0);
    check("R1 flag idle", int'(flag), 0);
    check("R1 shift_load idle", int'(shift_load), 0);

    // R6 R11 R12 R9 R14 R13: bit-rate sweep, stop on compare
    for (int li = 0; li < 3; li++) begin
      for (int hj = 0; hj < 3; hj++) begin
        for (int v = 0; v < 3; v++) begin
          defaults();
          cfg_mode = 2'd1; cfg_ena_sel = 3'd0; cfg_dis_sel = 3'd2;
          cfg_out_sel = {1'b0, 1'(li & 1)};
          cfg_start_en = (v == 1);
          cfg_stop_sel = (v == 2) ? 2'b10 : 2'b00;
          cmp_val = {8'(his[hj]), 8'(los[li])};
          do_reset();
          run_len(0, len, fo, fl, ef);
          check(v == 0 ? "R6 bit-rate run length" : (v == 1 ? "R11 start bit length" : "R12 stop period length"),
                len, (his[hj] + 1 + (v != 0 ? 1 : 0)) * (los[li] + 1));
          check("R9 start level", fo, (li & 1) ? 0 : 1);
          check("R14 load strobe at start", fl, 1);
          check("R13 flag after compare", ef, 1);
        end
      end
    end

    // R7: PWM high and low times
    for (int p = 0; p < 3; p++) begin
      int lv, hv, hc, lc;
      lv = (p == 0) ? 0 : (p == 1 ? 2 : 4);
      hv = (p == 0) ? 0 : (p == 1 ? 5 : 1);
      defaults();
      cfg_mode = 2'd2; cmp_val = {8'(hv), 8'(lv)};
      do_reset();
      while (!pin_oe) step(1);
      hc = 0; lc = 0;
      while (tmr_out && hc < 1000) begin hc++; step(1); end
      while (!tmr_out && lc < 1000) begin lc++; step(1); end
      check("R7 PWM high time", hc, lv + 1);
      check("R7 PWM low time", lc, hv + 1);
    end

    // R8: 16-bit interval
    for (int n = 0; n < 3; n++) begin
      int nv;
      nv = (n == 0) ? 0 : (n == 1 ? 5 : 300);
      defaults();
      cfg_mode = 2'd3; cfg_dis_sel = 3'd2; cmp_val = 16'(nv);
      do_reset();
      run_len(0, len, fo, fl, ef);
      check("R8 16-bit run length", len, nv + 1);
    end

    // R5: trigger rise reloads a 16-bit count partway through
    defaults();
    cfg_mode = 2'd3; cfg_dis_sel = 3'd2; cfg_rld_sel = 3'd6; cmp_val = 16'd20;
    do_reset();
    run_len(5, len, fo, fl, ef);
    check("R5 reload lengthens run", len, 27);

    // R3 R13: single-shot on trigger rise, flag holds then clears
    defaults();
    cfg_mode = 2'd3; cfg_ena_sel = 3'd6; cfg_dis_sel = 3'd2; cmp_val = 16'd3;
    do_reset();
    step(6);
    check("R3 no start without trigger rise", int'(pin_oe), 0);
    trg_in = 1'b1;
    run_len(0, len, fo, fl, ef);
    check("R3 trigger rise start length", len, 4);
    step(5);
    check("R13 flag holds", int'(flag), 1);
    check("R3 single shot stays idle", int'(pin_oe), 0);
    flag_clr = 1'b1;
    step(1);
    flag_clr = 1'b0;
    check("R13 flag cleared", int'(flag), 0);

    // R2: inverted trigger level start
    defaults();
    cfg_mode = 2'd3; cfg_ena_sel = 3'd2; cfg_trg_inv = 1'b1; cmp_val = 16'd1000;
    trg_in = 1'b1;
    do_reset();
    step(8);
    check("R2 high input is inactive when inverted", int'(pin_oe), 0);
    trg_in = 1'b0;
    step(3);
    check("R2 low input starts when inverted", int'(pin_oe), 1);

    // R3 R4: neighbour start and stop pulses
    defaults();
    cfg_mode = 2'd3; cfg_ena_sel = 3'd1; cfg_dis_sel = 3'd1; cmp_val = 16'd1000;
    do_reset();
    step(4);
    check("R3 idle before neighbour start", int'(pin_oe), 0);
    prev_en = 1'b1;
    step(1);
    prev_en = 1'b0;
    check("R3 neighbour start", int'(pin_oe), 1);
    step(4);
    prev_dis = 1'b1;
    step(1);
    prev_dis = 1'b0;
    check("R4 neighbour stop", int'(pin_oe), 0);

    // R10: ticks on trigger edges
    defaults();
    cfg_mode = 2'd3; cfg_ena_sel = 3'd1; cfg_dis_sel = 3'd2; cfg_dec_sel = 2'd1; cmp_val = 16'd2;
    do_reset();
    prev_en = 1'b1;
    step(1);
    prev_en = 1'b0;
    step(3);
    trg_in = 1'b1; step(4);
    trg_in = 1'b0; step(4);
    check("R10 running after two trigger edges", int'(pin_oe), 1);
    trg_in = 1'b1; step(4);
    check("R10 stopped after third trigger edge", int'(pin_oe), 0);
    check("R10 compare flagged by edge ticks", int'(flag), 1);

    // R10: shift clock follows pin or trigger
    defaults();
    cfg_dec_sel = 2'd2;
    do_reset();
    pin_in = 1'b1; step(2);
    check("R10 shift clock from pin high", int'(shift_clk), 1);
    pin_in = 1'b0; step(2);
    check("R10 shift clock from pin low", int'(shift_clk), 0);
    cfg_dec_sel = 2'd3; trg_in = 1'b1; step(2);
    check("R10 shift clock from trigger", int'(shift_clk), 1);

    // R1: mode 0 forces idle while enable is always true
    defaults();
    cfg_ena_sel = 3'd0;
    do_reset();
    step(10);
    check("R1 mode 0 never starts", int'(pin_oe), 0);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule